// File: doc/BRIEF.md
# Group-1 Operate Micro-Sequencer

This unit carries out the first-group operate instruction of a 12-bit accumulator machine. It takes the instruction word, the current accumulator and the current link bit, and it returns the new accumulator and link. One word can hold several micro-operations: clears, complements, an increment, and a rotate or a half-word swap. The unit applies them in a fixed logical order.

Each group of micro-operations runs in its own internal step. The steps are clear, complement, increment and then rotate. This keeps any combinational path to a single step. An operation is offered by raising `in_valid` for one cycle while the unit is idle. The result appears on registered outputs four clock edges after the accepting edge, together with a one-cycle `out_done` pulse. A new `in_valid` that arrives while the unit is busy is dropped.

Top module: `opr1_unit`

## Requirements
- R1: After synchronous active-high reset, `out_acc` = 0, `out_link` = 0, `out_done` = 0 and `busy` = 0.
- R2: Bits are numbered MSB-first 0..11, so bit n is `in_word[11-n]`. A word is in this group only when bits 0–2 are 111 and bit 3 is 0. Any other word is still accepted, but it returns the accumulator and link unchanged.
- R3: Clear step. Bit 4 set clears the accumulator and bit 5 set clears the link.
- R4: Complement step, after the clears. Bit 6 set inverts the accumulator and bit 7 set inverts the link. With bits 4 and 6 both set the result is 7777 (octal).
- R5: Increment step, after the complements. Bit 11 set adds one to the 13-bit value {link, acc}, so a carry out of the accumulator inverts the link.
- R6: Rotate step, last. With bit 10 = 0, bit 8 alone rotates {link, acc} right by one and bit 9 alone rotates it left by one.
- R7: With bit 10 = 1, bit 8 alone rotates {link, acc} right by two and bit 9 alone rotates it left by two.
- R8: With bits 8 and 9 both 0 and bit 10 = 1, the upper 6 accumulator bits swap with the lower 6 bits, and the link is unchanged.
- R9: With bits 8 and 9 both set, the rotate step changes nothing, whatever the value of bit 10.
- R10: An operation accepted at clock edge k shows its result after edge k+4. `out_done` is high for exactly that one cycle. The outputs hold their value at all other times.
- R11: While `busy` is high, `in_valid` is ignored: it produces no extra result and leaves the result in flight unchanged. `busy` rises after the accepting edge and falls when `out_done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Offer an operation (taken only while idle) |
| in_word | input | 12 | Instruction word |
| in_acc | input | 12 | Accumulator value to operate on |
| in_link | input | 1 | Link value to operate on |
| out_acc | output | 12 | Resulting accumulator (registered) |
| out_link | output | 1 | Resulting link (registered) |
| out_done | output | 1 | One-cycle pulse when a result is presented |
| busy | output | 1 | Operation in progress |

## Verification
A step sequencer that is in the wrong state would skip a stage, apply one twice, or move the done pulse. Any of these shows at the ports on the very next result: a wrong value, or a pulse that is early, late or missing. The bench checks the exact cycle of every pulse. Its stimulus includes combined micro-operations such as clear plus complement and complement plus increment. These expose an ordering fault in the one result where the order matters. A result register that latched while the unit was busy would show up as a second done pulse, or as a changed value from an operation that overlapped a running one.

// File: rtl/opr1_pkg.sv
package opr1_pkg;

    localparam int WORD_W = 12;
    localparam int ACC_W  = 12;
    localparam int HALF_W = ACC_W / 2;
    localparam int CTX_W  = ACC_W + 1;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CLR  = 3'd1,
        ST_CMP  = 3'd2,
        ST_INC  = 3'd3,
        ST_ROT  = 3'd4
    } step_e;

    typedef struct packed {
        logic clr_a;
        logic clr_l;
        logic cmp_a;
        logic cmp_l;
        logic inc;
        logic rot_r;
        logic rot_l;
        logic dbl;
    } uop_t;

    typedef struct packed {
        logic             link;
        logic [ACC_W-1:0] acc;
    } ctx_t;

    // MSB-first numbering: field n sits at word[WORD_W-1-n]
    function automatic logic fld(input logic [WORD_W-1:0] w, input int n);
        return w[WORD_W-1-n];
    endfunction

    function automatic ctx_t rot_right(input ctx_t x, input int unsigned by);
        logic [CTX_W-1:0] v;
        v = x;
        for (int i = 0; i < 2; i++)
            if (i < by) v = {v[0], v[CTX_W-1:1]};
        return v;
    endfunction

    function automatic ctx_t rot_left(input ctx_t x, input int unsigned by);
        logic [CTX_W-1:0] v;
        v = x;
        for (int i = 0; i < 2; i++)
            if (i < by) v = {v[CTX_W-2:0], v[CTX_W-1]};
        return v;
    endfunction

endpackage

// File: rtl/opr1_decode.sv
module opr1_decode
    import opr1_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output uop_t              uop
);
    logic in_group;

    always_comb begin
        in_group  = fld(word, 0) && fld(word, 1) && fld(word, 2) && !fld(word, 3);
        uop.clr_a = in_group && fld(word, 4);
        uop.clr_l = in_group && fld(word, 5);
        uop.cmp_a = in_group && fld(word, 6);
        uop.cmp_l = in_group && fld(word, 7);
        uop.rot_r = in_group && fld(word, 8);
        uop.rot_l = in_group && fld(word, 9);
        uop.dbl   = in_group && fld(word, 10);
        uop.inc   = in_group && fld(word, 11);
    end
endmodule

// File: rtl/opr1_ctrl.sv
module opr1_ctrl
    import opr1_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    output step_e step,
    output logic  accept,
    output logic  last,
    output logic  busy
);
    step_e step_q, step_d;

    always_comb begin
        step_d = step_q;
        unique case (step_q)
            ST_IDLE: if (in_valid) step_d = ST_CLR;
            ST_CLR:  step_d = ST_CMP;
            ST_CMP:  step_d = ST_INC;
            ST_INC:  step_d = ST_ROT;
            ST_ROT:  step_d = ST_IDLE;
            default: step_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= ST_IDLE;
        else     step_q <= step_d;
    end

    assign step   = step_q;
    assign busy   = (step_q != ST_IDLE);
    assign accept = (step_q == ST_IDLE) && in_valid;
    assign last   = (step_q == ST_ROT);

    // R11: a sequence starts only from idle, never mid-run
    assert_start_from_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_CLR) |-> ($past(step_q) == ST_IDLE));

    // R10: steps advance every cycle with no stall
    assert_steps_advance_R10: assert property (@(posedge clk) disable iff (rst)
        (step_q == ST_INC) |=> (step_q == ST_ROT));
endmodule

// File: rtl/opr1_alu.sv
module opr1_alu
    import opr1_pkg::*;
(
    input  step_e step,
    input  uop_t  uop,
    input  ctx_t  x,
    output ctx_t  y
);
    always_comb begin
        y = x;
        unique case (step)
            ST_CLR: begin
                if (uop.clr_a) y.acc  = '0;
                if (uop.clr_l) y.link = 1'b0;
            end
            ST_CMP: begin
                if (uop.cmp_a) y.acc  = ~x.acc;
                if (uop.cmp_l) y.link = ~x.link;
            end
            ST_INC: begin
                if (uop.inc) y = x + CTX_W'(1);
            end
            ST_ROT: begin
                if (uop.rot_r && !uop.rot_l)
                    y = rot_right(x, uop.dbl ? 2 : 1);
                else if (uop.rot_l && !uop.rot_r)
                    y = rot_left(x, uop.dbl ? 2 : 1);
                else if (!uop.rot_r && !uop.rot_l && uop.dbl)
                    y.acc = {x.acc[HALF_W-1:0], x.acc[ACC_W-1:HALF_W]};
            end
            default: y = x;
        endcase
    end
endmodule

// File: rtl/opr1_unit.sv
module opr1_unit
    import opr1_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic [ACC_W-1:0]  in_acc,
    input  logic              in_link,
    output logic [ACC_W-1:0]  out_acc,
    output logic              out_link,
    output logic              out_done,
    output logic              busy
);
    step_e step;
    logic  accept, last;
    uop_t  uop_now, uop_q;
    ctx_t  work_q, step_out, res_q;
    logic  done_q;

    opr1_decode u_dec (.word(in_word), .uop(uop_now));

    opr1_ctrl u_ctrl (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .step(step), .accept(accept), .last(last), .busy(busy)
    );

    opr1_alu u_alu (.step(step), .uop(uop_q), .x(work_q), .y(step_out));

    always_ff @(posedge clk) begin
        if (rst) begin
            uop_q  <= '0;
            work_q <= '0;
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= last;
            if (accept) begin
                uop_q  <= uop_now;
                work_q <= {in_link, in_acc};
            end else if (busy) begin
                work_q <= step_out;
            end
            if (last) res_q <= step_out;
        end
    end

    assign out_acc  = res_q.acc;
    assign out_link = res_q.link;
    assign out_done = done_q;

    // R10: done is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done);

    // R10: result holds except in the done cycle
    assert_result_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !out_done |-> ($stable(out_acc) && $stable(out_link)));

    // R3: clear step empties the accumulator
    assert_clear_acc_R3: assert property (@(posedge clk) disable iff (rst)
        (step == ST_CLR && uop_q.clr_a) |=> (work_q.acc == '0));

    // R4: complement step inverts the accumulator
    assert_cmp_acc_R4: assert property (@(posedge clk) disable iff (rst)
        (step == ST_CMP && uop_q.cmp_a) |=> (work_q.acc == ~$past(work_q.acc)));

    // R9: both rotate directions leave the value alone
    assert_rot_both_R9: assert property (@(posedge clk) disable iff (rst)
        (step == ST_ROT && uop_q.rot_r && uop_q.rot_l) |=> (res_q == $past(work_q)));

    // R11: busy is low whenever done is shown
    assert_idle_at_done_R11: assert property (@(posedge clk) disable iff (rst)
        out_done |-> !busy);
endmodule

// File: tb/opr1_unit_bench.sv
module opr1_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_word = '0;
    logic [11:0] in_acc = '0;
    logic        in_link = 1'b0;
    logic [11:0] out_acc;
    logic        out_link;
    logic        out_done;
    logic        busy;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [12:0] val;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    opr1_unit u_opr1_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
        .in_acc(in_acc), .in_link(in_link), .out_acc(out_acc),
        .out_link(out_link), .out_done(out_done), .busy(busy)
    );

    task automatic check(input logic ok, input string tag, input logic [12:0] act, input logic [12:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%o expected=%o", tag, act, exp);
        end
    endtask

    // Expected result built from the requirement text, MSB-first fields
    function automatic logic [12:0] model(input logic [11:0] a, input logic l, input logic [11:0] w);
        logic [12:0] x;
        logic rr, rl, tw;
        if (w[11:9] != 3'b111 || w[8]) return {l, a};          // R2
        if (w[7]) a = '0;                                        // R3
        if (w[6]) l = 1'b0;
        if (w[5]) a = ~a;                                        // R4
        if (w[4]) l = ~l;
        x = {l, a};
        if (w[0]) x = x + 13'd1;                                 // R5
        rr = w[3]; rl = w[2]; tw = w[1];
        if (rr && !rl)       x = tw ? {x[1:0], x[12:2]} : {x[0], x[12:1]};   // R6 R7
        else if (rl && !rr)  x = tw ? {x[10:0], x[12:11]} : {x[11:0], x[12]};
        else if (!rr && !rl && tw) x = {x[12], x[5:0], x[11:6]};              // R8
        return x;                                                             // R9
    endfunction

    // Monitor: pop expected item on each done pulse
    always @(negedge clk) begin
        if (!rst && out_done) begin
            if (sb.size() == 0) begin
                check(1'b0, "R11 unexpected done", {out_link, out_acc}, 13'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check({out_link, out_acc} === e.val, e.tag, {out_link, out_acc}, e.val);
            end
        end
    end

    // Driver: one operation, with optional overlapping valid pulses while busy
    task automatic run_op(input logic [11:0] a, input logic l, input logic [11:0] w,
                          input string tag, input bit poke);
        exp_t e;
        logic [12:0] held;
        @(negedge clk);
        in_acc = a; in_link = l; in_word = w; in_valid = 1'b1;
        e.val = model(a, l, w); e.tag = tag;
        sb.push_back(e);
        held = {out_link, out_acc};
        @(negedge clk);                        // after accepting edge k
        in_valid = 1'b0;
        check(busy === 1'b1, "R11 busy after accept", {12'd0, busy}, 13'd1);
        for (int i = 0; i < 3; i++) begin
            if (poke) begin
                in_valid = 1'b1; in_word = 12'o7240; in_acc = 12'o5555; in_link = ~l;
            end
            @(negedge clk);
            in_valid = 1'b0;
        end
        // after edge k+3: not yet done, outputs unchanged
        check(out_done === 1'b0, "R10 done too early", {12'd0, out_done}, 13'd0);
        check({out_link, out_acc} === held, "R10 output held", {out_link, out_acc}, held);
        @(negedge clk);                        // after edge k+4
        check(out_done === 1'b1, "R10 done at k+4", {12'd0, out_done}, 13'd1);
        check(busy === 1'b0, "R11 idle at done", {12'd0, busy}, 13'd0);
        @(negedge clk);
        check(out_done === 1'b0, "R10 single pulse", {12'd0, out_done}, 13'd0);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check({out_link, out_acc} === 13'd0, "R1 reset outputs", {out_link, out_acc}, 13'd0);
        check(out_done === 1'b0 && busy === 1'b0, "R1 reset flags", {11'd0, out_done, busy}, 13'd0);

        run_op(12'o1234, 1'b1, 12'o7200, "R3 clear acc", 0);
        run_op(12'o1234, 1'b1, 12'o7100, "R3 clear link", 0);
        run_op(12'o1234, 1'b0, 12'o7040, "R4 complement acc", 0);
        run_op(12'o1234, 1'b0, 12'o7020, "R4 complement link", 0);
        run_op(12'o1234, 1'b0, 12'o7240, "R4 clear then complement", 0);
        run_op(12'o1234, 1'b1, 12'o7120, "R4 clear then complement link", 0);
        run_op(12'o0017, 1'b0, 12'o7001, "R5 increment", 0);
        run_op(12'o7777, 1'b0, 12'o7001, "R5 carry into link", 0);
        run_op(12'o7777, 1'b1, 12'o7001, "R5 carry clears link", 0);
        run_op(12'o0005, 1'b0, 12'o7041, "R5 complement then increment", 0);
        run_op(12'o4321, 1'b1, 12'o7301, "R5 clears then increment", 0);
        run_op(12'o0001, 1'b0, 12'o7010, "R6 rotate right", 0);
        run_op(12'o4000, 1'b0, 12'o7004, "R6 rotate left", 0);
        run_op(12'o2525, 1'b1, 12'o7010, "R6 rotate right link in", 0);
        run_op(12'o0003, 1'b0, 12'o7012, "R7 rotate right twice", 0);
        run_op(12'o6000, 1'b1, 12'o7006, "R7 rotate left twice", 0);
        run_op(12'o1277, 1'b1, 12'o7002, "R8 half swap", 0);
        run_op(12'o7700, 1'b0, 12'o7042, "R8 complement then swap", 0);
        run_op(12'o1234, 1'b1, 12'o7014, "R9 both rotate", 0);
        run_op(12'o1234, 1'b0, 12'o7016, "R9 both rotate twice", 0);
        run_op(12'o1234, 1'b1, 12'o7000, "R2 no-op word", 0);
        run_op(12'o1234, 1'b1, 12'o7600, "R2 other group ignored", 0);
        run_op(12'o1234, 1'b1, 12'o1200, "R2 memory word ignored", 0);
        run_op(12'o0707, 1'b0, 12'o7011, "R11 overlap ignored", 1);
        run_op(12'o7070, 1'b1, 12'o7244, "R11 overlap ignored again", 1);

        for (int i = 0; i < 40; i++) begin
            logic [11:0] a;
            logic [11:0] w;
            a = 12'((i * 1237 + 91) ^ (i << 5));
            w = 12'o7000 | 12'((i * 37 + 11) & 8'hFF);
            run_op(a, i[0], w, "R6 sweep mixed", 0);
        end

        repeat (3) @(negedge clk);
        check(sb.size() == 0, "R11 all results seen", 13'(sb.size()), 13'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule